// File: doc/BRIEF.md
# YUV to RGB Pixel Color Converter

The converter turns one pixel per clock from Y, U and V samples into 8-bit R, G and B. Each output channel comes from one row of a 3x4 matrix held in twelve programmable registers. Three signed multipliers in the row scale Y, U and V, and a signed constant is added after them. U and V go into the multipliers as raw unsigned bytes, so any chroma centring has to be folded into the constant. After reset the matrix holds a standard-definition studio-range conversion, which takes Y in 16..235 and chroma in 16..240 to full-range RGB.

Pixels enter and leave through valid/ready handshakes across a fixed two-stage pipeline. When the output is stalled, the whole pipeline stops. A per-pixel bypass flag sends already-RGB data straight through, with the same latency. Software loads the matrix through a one-cycle write port. A write never splits a pixel, because each pixel takes a full snapshot of the matrix in the cycle it is accepted.

Top module: `yuv_rgb_csc`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. The matrix holds these defaults (index = row*4 + column): G row 0x04A7, 0x1E6F, 0x1CBF, 0x0877; R row 0x04A7, 0x0000, 0x0662, 0x3211; B row 0x04A7, 0x0812, 0x0000, 0x2EB1.
- R2: A write with `cfg_we` high loads register `cfg_addr` = row*4 + column. Row 0 drives G, row 1 drives R and row 2 drives B. Columns 0, 1 and 2 multiply Y (`in_c0`), U (`in_c1`) and V (`in_c2`), and column 3 is the constant. Multipliers take `cfg_wdata[12:0]` and constants take `cfg_wdata[13:0]`. Higher data bits, and writes to addresses 12..15, have no effect.
- R3: A multiplier is a two's-complement number with 10 fraction bits (1.0 = 0x400). A constant is a two's-complement number with 4 fraction bits (1.0 = 0x10). Y, U and V are unsigned.
- R4: Each channel is (Y*m0 + U*m1 + V*m2 + k*64 + 512) shifted right by 10 with floor. This rounds to nearest, with halves going up. The result is then clamped to 0..255.
- R5: When `bypass_en` is high on an accepted pixel, the outputs are `out_r` = `in_c0`, `out_g` = `in_c1` and `out_b` = `in_c2`, unchanged.
- R6: If the pipeline does not stall, a pixel accepted at clock edge n is presented with `out_valid` high after edge n+2.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_r`, `out_g`, `out_b` and `out_valid` hold.
- R8: A pixel accepted on the same edge as a coefficient write uses the old value. Every pixel uses the full matrix as it stood at its acceptance edge.
- R9: Pixels leave in the order they entered, with none lost or duplicated, for any pattern of `in_valid` and `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient index, row*4 + column |
| cfg_wdata | input | 32 | Coefficient write data |
| bypass_en | input | 1 | Pass this pixel through without conversion |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Converter can accept a pixel |
| in_c0 | input | 8 | Y sample (R in bypass) |
| in_c1 | input | 8 | U sample (G in bypass) |
| in_c2 | input | 8 | V sample (B in bypass) |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
The hardest cases to reach from the ports are a coefficient write landing on the same edge as a pixel acceptance, and a write landing while earlier pixels sit stalled in the pipeline. Either case would expose a pixel that mixes old and new coefficients. Directed steps force a write in the same cycle as an accepted pixel, and also hold `out_ready` low while rows are rewritten. A long random phase then overlaps sparse writes, bypass pixels, gaps and backpressure. The bench model updates its matrix only after it has computed the expected value for a pixel accepted on that edge.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int unsigned CSC_ROWS = 3;
  localparam int unsigned CSC_COLS = 4;

  // Power-on matrix, index = row*CSC_COLS + column; rows are G, R, B.
  function automatic logic [31:0] csc_default(input int unsigned idx);
    logic [31:0] v;
    case (idx)
      0:  v = 32'h0000_04A7;
      1:  v = 32'h0000_1E6F;
      2:  v = 32'h0000_1CBF;
      3:  v = 32'h0000_0877;
      4:  v = 32'h0000_04A7;
      5:  v = 32'h0000_0000;
      6:  v = 32'h0000_0662;
      7:  v = 32'h0000_3211;
      8:  v = 32'h0000_04A7;
      9:  v = 32'h0000_0812;
      10: v = 32'h0000_0000;
      11: v = 32'h0000_2EB1;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank #(
  parameter int unsigned N_REG  = 12,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned COEF_W = 14
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [REG_W-1:0]              wr_data,
  output logic [N_REG-1:0][COEF_W-1:0]  coef_o
);
  import csc_pkg::*;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wr_data[REG_W-1:COEF_W];

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    logic              hit;
    logic [COEF_W-1:0] val_q;
    logic [COEF_W-1:0] val_d;

    assign hit = wr_en && (wr_addr == ADDR_W'(i));

    always_comb begin
      val_d = val_q;
      if (hit) val_d = wr_data[COEF_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= COEF_W'(csc_default(i));
      else if (hit) val_q <= val_d;
    end

    assign coef_o[i] = val_q;
  end

endmodule

// File: rtl/csc_row_mac.sv
module csc_row_mac #(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned MUL_W    = 13,
  parameter int unsigned MUL_FRAC = 10,
  parameter int unsigned OFS_W    = 14,
  parameter int unsigned OFS_FRAC = 4,
  parameter int unsigned COEF_W   = 14
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         adv,
  input  logic [2:0][PIX_W-1:0]        pix_i,
  input  logic [3:0][COEF_W-1:0]       coef_i,
  input  logic [PIX_W-1:0]             pass_i,
  input  logic                         byp_i,
  output logic [PIX_W-1:0]             res_o
);
  localparam int unsigned PROD_W = MUL_W + PIX_W + 1;
  localparam int unsigned ACC_W  = PROD_W + 3;
  localparam int unsigned ALIGN  = MUL_FRAC - OFS_FRAC;
  localparam int signed   PIX_MAX = (1 << PIX_W) - 1;

  logic unused_mul_hi;
  assign unused_mul_hi = ^{coef_i[0][COEF_W-1:MUL_W], coef_i[1][COEF_W-1:MUL_W],
                           coef_i[2][COEF_W-1:MUL_W], coef_i[3][COEF_W-1:OFS_W]};

  // Stage 1: products, constant and pass-through byte captured together.
  logic signed [PROD_W-1:0] prod_d [3];
  logic signed [PROD_W-1:0] prod_q [3];
  logic signed [OFS_W-1:0]  ofs_q;
  logic [PIX_W-1:0]         pass_q;

  for (genvar j = 0; j < 3; j++) begin : g_mul
    logic signed [MUL_W-1:0]  m;
    logic signed [PROD_W-1:0] m_e;
    logic signed [PROD_W-1:0] x_e;
    assign m   = coef_i[j][MUL_W-1:0];
    assign m_e = m;
    assign x_e = {{(PROD_W-PIX_W){1'b0}}, pix_i[j]};
    always_comb prod_d[j] = m_e * x_e;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prod_q[j] <= '0;
      else if (adv) prod_q[j] <= prod_d[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q  <= '0;
      pass_q <= '0;
    end else if (adv) begin
      ofs_q  <= coef_i[3][OFS_W-1:0];
      pass_q <= pass_i;
    end
  end

  // Stage 2: sum, round, clamp, bypass select.
  logic signed [ACC_W-1:0] a0, a1, a2, ak, acc, quo;
  logic [PIX_W-1:0]        sat;
  logic [PIX_W-1:0]        res_d;

  always_comb begin
    a0  = prod_q[0];
    a1  = prod_q[1];
    a2  = prod_q[2];
    ak  = ofs_q;
    acc = a0 + a1 + a2 + (ak <<< ALIGN) + (ACC_W'(1) <<< (MUL_FRAC - 1));
    quo = acc >>> MUL_FRAC;
    if (quo < 0)                  sat = '0;
    else if (quo > ACC_W'(PIX_MAX)) sat = '1;
    else                          sat = quo[PIX_W-1:0];
    res_d = byp_i ? pass_q : sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   res_o <= '0;
    else if (adv) res_o <= res_d;
  end

endmodule

// File: rtl/yuv_rgb_csc.sv
module yuv_rgb_csc #(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned MUL_W    = 13,
  parameter int unsigned MUL_FRAC = 10,
  parameter int unsigned OFS_W    = 14,
  parameter int unsigned OFS_FRAC = 4,
  parameter int unsigned REG_W    = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              bypass_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_c0,
  input  logic [PIX_W-1:0]  in_c1,
  input  logic [PIX_W-1:0]  in_c2,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);
  import csc_pkg::*;

  localparam int unsigned N_ROW  = CSC_ROWS;
  localparam int unsigned N_COL  = CSC_COLS;
  localparam int unsigned N_REG  = N_ROW * N_COL;
  localparam int unsigned COEF_W = (OFS_W > MUL_W) ? OFS_W : MUL_W;

  logic [N_REG-1:0][COEF_W-1:0] coef_all;
  logic [2:0][PIX_W-1:0]        pix;
  logic [PIX_W-1:0]             row_res [N_ROW];
  logic                         adv;
  logic                         s1_valid_q, s1_valid_d;
  logic                         s1_byp_q, s1_byp_d;
  logic                         out_valid_d;

  assign pix = {in_c2, in_c1, in_c0};

  // One enable for every stage: stall only when output is held.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  csc_coef_bank #(
    .N_REG (N_REG), .ADDR_W(ADDR_W), .REG_W(REG_W), .COEF_W(COEF_W)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_addr(cfg_addr),
    .wr_data(cfg_wdata),
    .coef_o (coef_all)
  );

  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    // Row 0 is G (passes in_c1), row 1 is R (in_c0), row 2 is B (in_c2).
    localparam int unsigned PASS_IDX = (r == 0) ? 1 : ((r == 1) ? 0 : 2);
    csc_row_mac #(
      .PIX_W(PIX_W), .MUL_W(MUL_W), .MUL_FRAC(MUL_FRAC),
      .OFS_W(OFS_W), .OFS_FRAC(OFS_FRAC), .COEF_W(COEF_W)
    ) u_mac (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .pix_i (pix),
      .coef_i(coef_all[r*N_COL +: N_COL]),
      .pass_i(pix[PASS_IDX]),
      .byp_i (s1_byp_q),
      .res_o (row_res[r])
    );
  end

  assign out_g = row_res[0];
  assign out_r = row_res[1];
  assign out_b = row_res[2];

  always_comb begin
    s1_valid_d  = s1_valid_q;
    s1_byp_d    = s1_byp_q;
    out_valid_d = out_valid;
    if (adv) begin
      s1_valid_d  = in_valid;
      s1_byp_d    = bypass_en;
      out_valid_d = s1_valid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_byp_q   <= 1'b0;
      out_valid  <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_byp_q   <= s1_byp_d;
      out_valid  <= out_valid_d;
    end
  end

endmodule

// File: rtl/csc_chk.sv
module csc_chk #(
  parameter int unsigned PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_r,
  input logic [PIX_W-1:0] out_g,
  input logic [PIX_W-1:0] out_b
);
  logic [2:0] pend_q;
  logic       acc_in, acc_out;

  assign acc_in  = in_valid && in_ready;
  assign acc_out = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_q + {2'b0, acc_in} - {2'b0, acc_out};
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

  // R7
  stall_blocks_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_in ##1 in_ready |=> out_valid);

  // R9
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= 3'd2);

  // R9
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pend_q != 3'd0));

endmodule

bind yuv_rgb_csc csc_chk #(.PIX_W(PIX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_r    (out_r),
  .out_g    (out_g),
  .out_b    (out_b)
);

// File: tb/yuv_rgb_csc_tb.sv
`timescale 1ns/1ps
module yuv_rgb_csc_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        bypass_en;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_c0, in_c1, in_c2;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_r, out_g, out_b;

  always #2.5 clk = ~clk;

  yuv_rgb_csc u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bypass_en(bypass_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int    errs = 0;
  int    checks = 0;
  int    cyc = 0;
  int    n_in = 0;
  int    n_out = 0;
  int    cm [12];
  int    exp_q [$];
  int    stamp_q [$];
  string tag_q [$];
  string cur_tag = "R1";
  bit    lat_mode = 0;
  bit    prev_stall = 0;
  int    prev_out = 0;
  bit    done = 0;

  function automatic int sx(int v, int w);
    int m;
    m = v & ((1 << w) - 1);
    if (m >= (1 << (w - 1))) m = m - (1 << w);
    return m;
  endfunction

  function automatic int chan(int row, int y, int u, int v);
    int acc;
    int q;
    acc = sx(cm[row*4], 13) * y + sx(cm[row*4+1], 13) * u + sx(cm[row*4+2], 13) * v
        + sx(cm[row*4+3], 14) * 64 + 512;
    q = acc >>> 10;
    if (q < 0) q = 0;
    if (q > 255) q = 255;
    return q;
  endfunction

  function automatic int expect_px(int y, int u, int v, bit byp);
    if (byp) return (y << 16) | (u << 8) | v;
    return (chan(1, y, u, v) << 16) | (chan(0, y, u, v) << 8) | chan(2, y, u, v);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%06h expected=%06h", tag, act, expv);
    end
  endtask

  task automatic step(bit iv, int a, int b, int c, bit byp, bit ordy,
                      bit we, int ad, logic [31:0] wd);
    int cur;
    @(negedge clk);
    in_valid  = iv;
    in_c0     = a[7:0];
    in_c1     = b[7:0];
    in_c2     = c[7:0];
    bypass_en = byp;
    out_ready = ordy;
    cfg_we    = we;
    cfg_addr  = ad[3:0];
    cfg_wdata = wd;
    #1;
    cyc++;
    cur = {8'h0, out_r, out_g, out_b};
    if (prev_stall) begin
      // R7: stalled output holds and blocks input
      chk(out_valid && cur == prev_out, "R7", cur, prev_out);
    end
    if (out_valid && !out_ready) chk(!in_ready, "R7", int'(in_ready), 0);
    prev_stall = out_valid && !out_ready;
    prev_out   = cur;
    if (out_valid && out_ready) begin
      n_out++;
      if (exp_q.size() == 0) begin
        chk(0, "R9", cur, -1);
      end else begin
        int e;
        int s;
        string t;
        e = exp_q.pop_front();
        s = stamp_q.pop_front();
        t = tag_q.pop_front();
        chk(cur == e, t, cur, e);
        if (lat_mode) chk(cyc - s == 2, "R6", cyc - s, 2);
      end
    end
    if (in_valid && in_ready) begin
      n_in++;
      exp_q.push_back(expect_px(a & 255, b & 255, c & 255, byp));
      stamp_q.push_back(cyc);
      tag_q.push_back(byp ? "R5" : cur_tag);
    end
    // R8: model matrix changes after the pixel of this edge is computed
    if (we && ad < 12) cm[ad] = int'(wd & 32'h3FFF);
  endtask

  task automatic px(int a, int b, int c);
    step(1, a, b, c, 0, 1, 0, 0, 0);
  endtask

  task automatic wr(int ad, logic [31:0] wd);
    step(0, 0, 0, 0, 0, 1, 1, ad, wd);
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic load_defaults();
    int d [12] = '{32'h04A7, 32'h1E6F, 32'h1CBF, 32'h0877,
                   32'h04A7, 32'h0000, 32'h0662, 32'h3211,
                   32'h04A7, 32'h0812, 32'h0000, 32'h2EB1};
    for (int i = 0; i < 12; i++) wr(i, d[i]);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    cm = '{32'h04A7, 32'h1E6F, 32'h1CBF, 32'h0877,
           32'h04A7, 32'h0000, 32'h0662, 32'h3211,
           32'h04A7, 32'h0812, 32'h0000, 32'h2EB1};
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 0; in_c0 = 0; in_c1 = 0; in_c2 = 0;
    bypass_en = 0; out_ready = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 and R6: defaults, back-to-back, no stall
    lat_mode = 1;
    cur_tag = "R1";
    px(16, 128, 128); px(235, 128, 128); px(81, 90, 240); px(128, 16, 240);
    cur_tag = "R4";
    px(0, 0, 0); px(255, 255, 255); px(0, 255, 0); px(255, 0, 255);
    drain(3);
    lat_mode = 0;

    // R2: row/column mapping, upper data bits ignored
    cur_tag = "R2";
    wr(4, 32'hFFFF_0400); wr(5, 0); wr(6, 0); wr(7, 32'hABCD_0000);
    wr(0, 0); wr(1, 32'h0000_0400); wr(2, 0); wr(3, 0);
    wr(8, 0); wr(9, 0); wr(10, 32'h0000_0400); wr(11, 0);
    px(37, 200, 9); px(250, 3, 128);
    // R2: out-of-range addresses have no effect
    wr(12, 32'hFFFF_FFFF); wr(13, 32'h0000_1234); wr(14, 32'h0); wr(15, 32'h3FFF);
    px(11, 22, 33);
    drain(3);

    // R3: negative constant and negative multiplier
    cur_tag = "R3";
    wr(7, 32'h0000_3FF0);
    px(0, 0, 0); px(100, 0, 0);
    wr(5, 32'h0000_1C00);
    px(200, 50, 0); px(10, 200, 0);
    drain(3);

    // R4: rounding of halves and clamping
    cur_tag = "R4";
    wr(0, 32'h0000_0200); wr(1, 0); wr(2, 0); wr(3, 0);
    px(1, 0, 0); px(3, 0, 0); px(4, 0, 0);
    wr(0, 0); wr(3, 32'h0000_0008);
    px(9, 9, 9);
    wr(3, 32'h0000_1FF0);
    px(0, 0, 0);
    drain(3);

    // R5: bypass
    step(1, 12, 34, 56, 1, 1, 0, 0, 0);
    step(1, 255, 0, 128, 1, 1, 0, 0, 0);
    drain(3);

    // R8: write on the same edge as an accepted pixel, then during a stall
    cur_tag = "R8";
    load_defaults();
    step(1, 90, 60, 200, 0, 1, 1, 4, 32'h0000_0800);
    step(1, 90, 60, 200, 0, 1, 1, 7, 32'h0000_0000);
    px(90, 60, 200);
    step(1, 20, 30, 40, 0, 1, 0, 0, 0);
    step(1, 50, 60, 70, 0, 0, 1, 4, 32'h0000_0400);
    step(1, 80, 90, 99, 0, 0, 1, 5, 32'h0000_0100);
    step(0, 0, 0, 0, 0, 0, 1, 0, 32'h0000_0000);
    drain(4);

    // R9: random traffic with backpressure, gaps, writes, bypass
    load_defaults();
    cur_tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      bit w;
      w = ($urandom % 24) == 0;
      step(($urandom % 4) != 0, $urandom % 256, $urandom % 256, $urandom % 256,
           ($urandom % 6) == 0, ($urandom % 3) != 0,
           w, $urandom % 16, w ? ($urandom & 32'h0000_07FF) : 32'h0);
    end
    drain(6);
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
    chk(n_in == n_out, "R9", n_out, n_in);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule